// File: doc/BRIEF.md
# Indexed Shadow-Memory Configuration Unit

This block is a configuration unit that sits on an 8-bit I/O bus and decides where CPU accesses to upper memory go. Software first writes a register number to an index port, then reads or writes the chosen register through a data port. Every register keeps only the bits its own write mask allows. A write to a register number that is not implemented is dropped.

The stored values feed a combinational segment decoder. For each memory access it reports whether the access goes to internal DRAM or to the external bus. The upper area from A0000h to FFFFFh is split into two 64 KB video segments, four 16 KB option-ROM segments at C0000h through CC000h, and three 64 KB segments at D0000h, E0000h and F0000h. Reads and writes have separate enables for the ROM and BIOS segments. Two bits of one register are brought out as enables for a neighbouring fast-reset / A20 gate block.

Top module: `shadow_cfg_ctrl`

## Requirements
- R1: An I/O write to address 0022h loads the register index. An I/O write to 0023h stores (data AND mask) into the register selected by the index.
- R2: On an I/O read, io_rdata takes a new value one clock later. That value is the indexed register when the address is 0023h, and FFh for any other address. Without a read, io_rdata holds.
- R3: The write masks are: 1Ch→B3h, 1Bh→FFh, 18h→F3h, 19h and 1Ah→7Fh, 14h–17h→7Fh, 11h–13h→8Dh, 10h→3Dh, 07h→0Fh, 06h→BCh, 05h→3Fh.
- R4: A data-port write to any index not listed in R3 changes no register. Such an index reads back as 00h.
- R5: After reset, register 05h holds 05h, register 1Bh holds 60h, every other register holds 00h, the index is 00h and io_rdata is FFh.
- R6: Register 18h bit 0 sends reads and writes in A0000h–AFFFFh to internal memory when set, and to the external bus when clear. Bit 1 does the same for B0000h–BFFFFh.
- R7: For reads, register 19h bits 0–3 select internal memory for the 16 KB segments C0000h, C4000h, C8000h and CC000h in that order. Bits 4, 5 and 6 do the same for the 64 KB segments D0000h, E0000h and F0000h.
- R8: Register 1Ah uses the bit-to-segment mapping of R7, but for writes.
- R9: gate_feat_en[0] equals register 1Ch bit 4, and gate_feat_en[1] equals register 1Ch bit 5.
- R10: mem_internal is 1 for any strobed access below A0000h and 0 when neither strobe is active. When both strobes are active, it is 1 only if both the read and the write would select internal memory.
- R11: mem_internal is combinational from the stored registers. An access in the same cycle as a register write sees the old setting, and the access in the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| mem_addr | input | 20 | CPU memory address |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| mem_internal | output | 1 | 1 routes the access to internal DRAM, 0 to the external bus |
| gate_feat_en | output | 2 | Enables for the fast-reset / A20 gate block |

## Verification
A write to a shadow-enable register and a memory access to the segment that register controls can fall in the same clock cycle. The bench provokes this by driving a data-port write to register 19h and a read of C0000h together. It samples mem_internal in that cycle, before the edge, and expects the old routing. It samples again in the next cycle and expects the new routing. A reference model held in bench arrays is checked against every output on every clock, so any overlap of configuration writes with decoded accesses is judged the same way.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;

  localparam int DW = 8;

  // {implemented, mask}
  function automatic logic [DW:0] wr_mask(input logic [7:0] idx);
    logic [DW:0] r;
    case (idx)
      8'h05:                      r = 9'h13F;
      8'h06:                      r = 9'h1BC;
      8'h07:                      r = 9'h10F;
      8'h10:                      r = 9'h13D;
      8'h11, 8'h12, 8'h13:        r = 9'h18D;
      8'h14, 8'h15, 8'h16, 8'h17: r = 9'h17F;
      8'h18:                      r = 9'h1F3;
      8'h19, 8'h1A:               r = 9'h17F;
      8'h1B:                      r = 9'h1FF;
      8'h1C:                      r = 9'h1B3;
      default:                    r = 9'h000;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] rst_val(input logic [7:0] idx);
    logic [DW-1:0] r;
    case (idx)
      8'h05:   r = 8'h05;
      8'h1B:   r = 8'h60;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/shcfg_busif.sv
module shcfg_busif #(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter logic [15:0] INDEX_PORT = 16'h0022,
  parameter logic [15:0] DATA_PORT  = 16'h0023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic [7:0]    idx,
  output logic          reg_wr,
  output logic [DW-1:0] io_rdata
);

  localparam logic [DW-1:0] FLOAT = '1;

  logic hit_index, hit_data;
  assign hit_index = (io_addr == AW'(INDEX_PORT));
  assign hit_data  = (io_addr == AW'(DATA_PORT));
  assign reg_wr    = io_wr && hit_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      io_rdata <= FLOAT;
    end else begin
      if (io_wr && hit_index) idx <= io_wdata[7:0];
      if (io_rd) io_rdata <= hit_data ? reg_rdata : FLOAT;
    end
  end

  // R2: a read of a port other than the data port returns all ones
  a_r2_other_port_ff: assert property (@(posedge clk) disable iff (rst)
    io_rd && !hit_data |=> io_rdata == FLOAT);

  // R2: read data holds while no read strobe is seen
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

// File: rtl/shcfg_regbank.sv
module shcfg_regbank
  import shcfg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int RW       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           idx,
  input  logic [RW-1:0]        wdata,
  output logic [RW-1:0]        rdata,
  output logic [NUM_REGS*RW-1:0] flat
);

  localparam int IW = $clog2(NUM_REGS);

  logic [RW-1:0] regs [NUM_REGS];
  logic [RW:0]   m;
  logic          in_range, hit;
  logic [IW-1:0] aidx;

  always_comb begin
    m        = wr_mask(idx);
    in_range = int'(idx) < NUM_REGS;
    hit      = in_range && m[RW];
    aidx     = idx[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_val(8'(i));
    end else if (wr_en && hit) begin
      regs[aidx] <= wdata & m[RW-1:0];
    end
  end

  assign rdata = in_range ? regs[aidx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign flat[g*RW +: RW] = regs[g];
  end

  // R4: data writes to an unimplemented index leave every register untouched
  a_r4_unlisted_hold: assert property (@(posedge clk) disable iff (rst)
    wr_en && !hit |=> $stable(flat));

  // R3: bits outside the mask are zero after a write
  a_r3_mask_clear: assert property (@(posedge clk) disable iff (rst)
    wr_en && hit |=> (regs[$past(aidx)] & ~$past(m[RW-1:0])) == '0);

endmodule

// File: rtl/shcfg_seg_decode.sv
module shcfg_seg_decode #(
  parameter int AW      = 20,
  parameter int SUB_SEG = 4,
  parameter int BIG_SEG = 3
) (
  input  logic                       rd,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [1:0]                 video_en,
  input  logic [SUB_SEG+BIG_SEG-1:0] rd_en,
  input  logic [SUB_SEG+BIG_SEG-1:0] wr_en,
  output logic                       internal
);

  localparam int SEGN = SUB_SEG + BIG_SEG;
  localparam int SW   = $clog2(SUB_SEG);

  logic [3:0]    seg;
  logic [SW-1:0] sub;
  logic [SEGN-1:0] sel;
  logic rd_int, wr_int, any;

  assign seg = addr[AW-1 -: 4];
  assign sub = addr[AW-5 -: SW];

  // one-hot segment select for the ROM/BIOS area
  for (genvar g = 0; g < SEGN; g++) begin : g_sel
    if (g < SUB_SEG) begin : g_small
      assign sel[g] = (seg == 4'hC) && (sub == SW'(g));
    end else begin : g_large
      assign sel[g] = (seg == 4'(13 + g - SUB_SEG));
    end
  end

  always_comb begin
    if (seg < 4'hA) begin
      rd_int = 1'b1;
      wr_int = 1'b1;
    end else if (seg == 4'hA) begin
      rd_int = video_en[0];
      wr_int = video_en[0];
    end else if (seg == 4'hB) begin
      rd_int = video_en[1];
      wr_int = video_en[1];
    end else begin
      rd_int = |(sel & rd_en);
      wr_int = |(sel & wr_en);
    end
    any      = rd || wr;
    internal = any && (!rd || rd_int) && (!wr || wr_int);
  end

endmodule

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl #(
  parameter int NUM_REGS = 32,
  parameter int IO_AW    = 16,
  parameter int MEM_AW   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              mem_internal,
  output logic [1:0]        gate_feat_en
);

  localparam int RW       = 8;
  localparam int IDX_VID  = 'h18;
  localparam int IDX_RDEN = 'h19;
  localparam int IDX_WREN = 'h1A;
  localparam int IDX_GATE = 'h1C;

  logic [7:0]             idx;
  logic                   reg_wr;
  logic [RW-1:0]          reg_rdata;
  logic [NUM_REGS*RW-1:0] flat;
  logic [RW-1:0]          r_vid, r_rden, r_wren, r_gate;

  shcfg_busif #(.AW(IO_AW), .DW(RW)) u_busif (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .reg_rdata(reg_rdata), .idx(idx), .reg_wr(reg_wr),
    .io_rdata(io_rdata)
  );

  shcfg_regbank #(.NUM_REGS(NUM_REGS), .RW(RW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(idx), .wdata(io_wdata),
    .rdata(reg_rdata), .flat(flat)
  );

  assign r_vid  = flat[IDX_VID*RW  +: RW];
  assign r_rden = flat[IDX_RDEN*RW +: RW];
  assign r_wren = flat[IDX_WREN*RW +: RW];
  assign r_gate = flat[IDX_GATE*RW +: RW];

  shcfg_seg_decode #(.AW(MEM_AW)) u_dec (
    .rd(mem_rd), .wr(mem_wr), .addr(mem_addr), .video_en(r_vid[1:0]),
    .rd_en(r_rden[6:0]), .wr_en(r_wren[6:0]), .internal(mem_internal)
  );

  assign gate_feat_en = r_gate[5:4];

  // R10: conventional memory is always internal for a strobed access
  a_r10_low_internal: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) && mem_addr < MEM_AW'('hA0000) |-> mem_internal);

  // R10: no strobe, no internal select
  a_r10_idle_external: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd || mem_wr) |-> !mem_internal);

endmodule

// File: tb/shadow_cfg_ctrl_bench.sv
module shadow_cfg_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic        mem_internal;
  logic [1:0]  gate_feat_en;

  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  shadow_cfg_ctrl u_shadow_cfg_ctrl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_internal(mem_internal),
    .gate_feat_en(gate_feat_en)
  );

  // ---------------- reference model ----------------
  int m_reg [256];
  int m_idx;
  int m_rdata;

  function automatic int ref_mask(int i);
    if (i == 'h1C) return 'hB3;
    if (i == 'h1B) return 'hFF;
    if (i == 'h18) return 'hF3;
    if (i == 'h19 || i == 'h1A) return 'h7F;
    if (i >= 'h14 && i <= 'h17) return 'h7F;
    if (i >= 'h11 && i <= 'h13) return 'h8D;
    if (i == 'h10) return 'h3D;
    if (i == 'h07) return 'h0F;
    if (i == 'h06) return 'hBC;
    if (i == 'h05) return 'h3F;
    return -1;
  endfunction

  function automatic int ref_route(int a, bit is_wr);
    int r;
    r = is_wr ? m_reg['h1A] : m_reg['h19];
    if (a < 'hA0000) return 1;
    if (a < 'hB0000) return m_reg['h18] & 1;
    if (a < 'hC0000) return (m_reg['h18] >> 1) & 1;
    if (a < 'hD0000) return (r >> ((a - 'hC0000) / 'h4000)) & 1;
    return (r >> (4 + (a - 'hD0000) / 'h10000)) & 1;
  endfunction

  function automatic int ref_internal();
    int v;
    if (!mem_rd && !mem_wr) return 0;
    v = 1;
    if (mem_rd) v = v & ref_route(int'(mem_addr), 1'b0);
    if (mem_wr) v = v & ref_route(int'(mem_addr), 1'b1);
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-edge comparison: decoder before the edge, then model update
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 256; i++) m_reg[i] = 0;
      m_reg['h05] = 'h05;
      m_reg['h1B] = 'h60;
      m_idx = 0;
      m_rdata = 'hFF;
    end else begin
      check("R11 R6 R7 R8 R10 mem_internal", int'(mem_internal), ref_internal());
      if (io_rd) m_rdata = (io_addr == 16'h0023) ? m_reg[m_idx] : 'hFF;
      if (io_wr && io_addr == 16'h0022) m_idx = int'(io_wdata);
      if (io_wr && io_addr == 16'h0023 && ref_mask(m_idx) >= 0)
        m_reg[m_idx] = int'(io_wdata) & ref_mask(m_idx);
    end
  end

  // Registered outputs compared away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 io_rdata", int'(io_rdata), m_rdata);
      check("R9 gate_feat_en", int'(gate_feat_en), (m_reg['h1C] >> 4) & 3);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    io_wr = 0; io_rd = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); #1;
    idle(); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); #1; idle();
  endtask

  task automatic io_read_chk(logic [15:0] a, int exp, string tag);
    @(negedge clk); #1;
    idle(); io_addr = a; io_rd = 1;
    @(negedge clk); #1; idle();
    check(tag, int'(io_rdata), exp);
  endtask

  task automatic reg_chk(int i, int exp, string tag);
    io_write(16'h0022, 8'(i));
    io_read_chk(16'h0023, exp, tag);
  endtask

  task automatic reg_set(int i, int d);
    io_write(16'h0022, 8'(i));
    io_write(16'h0023, 8'(d));
  endtask

  task automatic mem_chk(int a, bit r, bit w, int exp, string tag);
    @(negedge clk); #1;
    idle(); mem_addr = 20'(a); mem_rd = r; mem_wr = w;
    #2 check(tag, int'(mem_internal), exp);
    @(negedge clk); #1; idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 0;
    // R5: reset state
    @(negedge clk); #1;
    check("R5 io_rdata after reset", int'(io_rdata), 'hFF);
    check("R9 R5 gate after reset", int'(gate_feat_en), 0);
    io_read_chk(16'h0023, 'h00, "R5 index 0 reads 00");
    reg_chk('h05, 'h05, "R5 reg05");
    reg_chk('h1B, 'h60, "R5 reg1B");
    reg_chk('h18, 'h00, "R5 reg18");
    reg_chk('h1A, 'h00, "R5 reg1A");

    // R3 / R4: write all ones then a pattern across the index range
    for (int i = 0; i < 40; i++) begin
      reg_set(i, 'hFF);
      reg_chk(i, ref_mask(i) < 0 ? 0 : ref_mask(i), "R3 R4 mask readback");
    end
    for (int i = 0; i < 40; i++) begin
      reg_set(i, 'h5A);
      reg_chk(i, ref_mask(i) < 0 ? 0 : ('h5A & ref_mask(i)), "R3 R4 pattern");
    end
    reg_chk('h05, 'h1A, "R4 reg05 unchanged by neighbours");
    reg_set('hC3, 'hFF);
    reg_chk('hC3, 'h00, "R4 high index ignored");

    // R1: index then data
    reg_set('h14, 'h81);
    reg_chk('h14, 'h01, "R1 store masked");
    // R2: read of the index port
    io_read_chk(16'h0022, 'hFF, "R2 index port reads FF");
    io_read_chk(16'h0080, 'hFF, "R2 foreign port reads FF");

    // R6
    reg_set('h18, 'h01);
    mem_chk('hA0000, 1, 0, 1, "R6 A seg read internal");
    mem_chk('hAFFFF, 0, 1, 1, "R6 A seg write internal");
    mem_chk('hB8000, 1, 0, 0, "R6 B seg external");
    reg_set('h18, 'h02);
    mem_chk('hA4000, 0, 1, 0, "R6 A seg external");
    mem_chk('hB0000, 0, 1, 1, "R6 B seg internal");

    // R7 / R8
    reg_set('h19, 'h05);
    reg_set('h1A, 'h52);
    mem_chk('hC0000, 1, 0, 1, "R7 C0000 read");
    mem_chk('hC0000, 0, 1, 0, "R8 C0000 write");
    mem_chk('hC4000, 1, 0, 0, "R7 C4000 read");
    mem_chk('hC4000, 0, 1, 1, "R8 C4000 write");
    mem_chk('hCBFFF, 1, 0, 1, "R7 C8000 read");
    mem_chk('hD0000, 1, 0, 0, "R7 D seg read");
    mem_chk('hDFFFF, 0, 1, 1, "R8 D seg write");
    mem_chk('hE8000, 0, 1, 0, "R8 E seg write");
    mem_chk('hF0000, 0, 1, 1, "R8 F seg write");
    mem_chk('hF0000, 1, 0, 0, "R7 F seg read");

    // R10
    mem_chk('h12345, 1, 0, 1, "R10 low read internal");
    mem_chk('h9FFFF, 0, 1, 1, "R10 low write internal");
    mem_chk('hC0000, 0, 0, 0, "R10 idle external");
    mem_chk('hC0000, 1, 1, 0, "R10 both strobes mixed");
    mem_chk('hC4000 + 'h8000, 1, 1, 0, "R10 both strobes CC000");

    // sweep every 16 KB step for both strobes (model compares each edge)
    for (int pat = 0; pat < 3; pat++) begin
      reg_set('h19, 'h2B + pat * 'h11);
      reg_set('h1A, 'h74 - pat * 'h13);
      for (int a = 'h90000; a < 'h100000; a += 'h4000) begin
        mem_chk(a, 1, 0, ref_route(a, 1'b0), "R7 sweep");
        mem_chk(a, 0, 1, ref_route(a, 1'b1), "R8 sweep");
      end
    end

    // R9
    reg_set('h1C, 'h30);
    @(negedge clk); check("R9 both gate bits", int'(gate_feat_en), 3);
    reg_set('h1C, 'h10);
    @(negedge clk); check("R9 bit4 only", int'(gate_feat_en), 1);
    reg_set('h1C, 'hEF);
    @(negedge clk); check("R9 bit5 only", int'(gate_feat_en), 2);

    // R11: register write and access in the same cycle
    reg_set('h19, 'h00);
    io_write(16'h0022, 8'h19);
    @(negedge clk); #1;
    idle(); io_addr = 16'h0023; io_wdata = 8'h01; io_wr = 1;
    mem_addr = 20'hC0000; mem_rd = 1;
    #2 check("R11 same cycle sees old", int'(mem_internal), 0);
    @(negedge clk); #1;
    io_wr = 0;
    #2 check("R11 next cycle sees new", int'(mem_internal), 1);
    @(negedge clk); #1; idle();

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule